// File: doc/BRIEF.md
# E1 CRC-4 Multiframe Aligner with Automatic Interworking

This block sits behind an E1 basic frame aligner. It receives one strobe per received frame, a flag that tells whether the frame is an odd (non-alignment) frame, and the first bit of timeslot 0 of that frame. From these inputs it finds the 16-frame CRC-4 multiframe. The alignment word 001011 is spread over bit 1 of the odd frames at multiframe positions 1, 3, 5, 7, 9 and 11. The block confirms a candidate against the following multiframe before it reports lock. Once locked, it reports the position of every received frame within the multiframe.

The block also decides, one time only, whether the far end runs CRC-4. A frame-counting timer starts when basic frame alignment is gained. If multiframe lock has not been reached when the timer expires, and interworking is enabled, the far end is taken as non-CRC-4. Receive CRC-4 processing is then switched off, the transmitter is told to send its E-bits as zero, and a status bit goes high. That decision holds until basic alignment is lost or the block is reset, even if CRC-4 lock is gained later.

Top module: `crc4_mf_align`

## Requirements
- R1: A lock candidate is taken when the last six odd-frame bits, oldest first, read 001011, and all six were received since basic alignment was gained. The frame that carries the final 1 is multiframe position 11.
- R2: Lock requires the same word again, ending exactly 16 frames after the candidate. `crc_sync_n` (active low, 0 = locked) falls in the clock cycle after the strobe of that confirming frame.
- R3: If the confirming word does not match, the block goes back to searching. No lock is reported until a new candidate is confirmed one multiframe later.
- R4: While locked, `mf_pos` gives the multiframe position (0..15) of the most recent frame, and it advances by one (mod 16) on each frame strobe. While not locked it reads 0.
- R5: After reset, or in the cycle after `bas_sync` is low: `crc_sync_n`=1, `iw_status`=0, `tx_ebit_zero`=0, `rx_crc_en`=0 and `mf_pos`=0.
- R6: If `interwork_off`=0 and no lock has been reached by the TIMEOUT_FRAMES-th frame strobe since `bas_sync` rose, then after that strobe `iw_status`=1, `tx_ebit_zero`=1 and `rx_crc_en`=0.
- R7: A lock reached on or before the TIMEOUT_FRAMES-th frame fixes CRC-4 working: `iw_status` stays 0, and `rx_crc_en`=1 while locked.
- R8: A lock reached after non-CRC-4 working was chosen drives `crc_sync_n` to 0, but `iw_status` and `tx_ebit_zero` stay 1 and `rx_crc_en` stays 0.
- R9: With `interwork_off`=1 at the expiry frame, `iw_status` never rises, and the search continues until lock.
- R10: Clock cycles with `frm_valid`=0, and all strobes while `bas_sync`=0, change no state and no output.
- R11: Bit 1 of even frames (`frm_nfas`=0) takes no part in the alignment search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bas_sync | input | 1 | Basic frame alignment is held (1) |
| frm_valid | input | 1 | One-cycle strobe per received frame |
| frm_nfas | input | 1 | The strobed frame is an odd (non-alignment) frame |
| frm_bit1 | input | 1 | Bit 1 of timeslot 0 of the strobed frame |
| interwork_off | input | 1 | 0 enables automatic interworking, 1 disables it |
| crc_sync_n | output | 1 | CRC-4 multiframe lock, active low |
| iw_status | output | 1 | Non-CRC-4 far end has been chosen |
| rx_crc_en | output | 1 | Receive CRC-4 processing enabled |
| tx_ebit_zero | output | 1 | Transmit E-bits forced to zero |
| mf_pos | output | 4 | Multiframe position of the last frame while locked |

## Verification
A wrong alignment phase in the search window or the position counter shows at the ports as a lock that comes a multiframe early or late, or as an `mf_pos` that is off from the true frame phase on every frame after lock. Both show up within one multiframe of the event. A timer that is off by one frame flips the interworking decision only when lock falls right at the expiry frame. For this reason the stimulus places lock exactly on the expiry frame and on the frame after it. A decision latch that does not hold shows as `iw_status` or `rx_crc_en` changing on the frames that follow a late lock.

// File: rtl/crc4_mf_pkg.sv
package crc4_mf_pkg;
    localparam logic [5:0] MFA_WORD     = 6'b001011;
    localparam int         MFA_BITS     = $bits(MFA_WORD);
    localparam int         MF_FRAMES    = 16;
    localparam int         POS_W        = $clog2(MF_FRAMES);
    localparam logic [POS_W-1:0] MFA_END_POS = POS_W'(11);

    typedef enum logic [1:0] {
        LK_HUNT    = 2'd0,
        LK_CONFIRM = 2'd1,
        LK_LOCKED  = 2'd2
    } lock_state_e;
endpackage

// File: rtl/crc4_mfa_window.sv
module crc4_mfa_window
    import crc4_mf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic shift_en,
    input  logic bit_in,
    output logic match
);
    localparam int FILL_W = $clog2(MFA_BITS + 1);

    typedef struct packed {
        logic [MFA_BITS-1:0] win;
        logic [FILL_W-1:0]   fill;
    } win_regs_t;

    win_regs_t win_d, win_q;
    logic [MFA_BITS-1:0] win_next;
    logic                full_next;

    always_comb begin
        win_d     = win_q;
        win_next  = {win_q.win[MFA_BITS-2:0], bit_in};
        full_next = (win_q.fill >= FILL_W'(MFA_BITS - 1));
        match     = shift_en && full_next && (win_next == MFA_WORD);
        if (clear) begin
            win_d = '0;
        end else if (shift_en) begin
            win_d.win = win_next;
            if (win_q.fill != FILL_W'(MFA_BITS))
                win_d.fill = FILL_W'(win_q.fill + 1'b1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    // R1: a match is never reported before six bits were gathered since the clear
    a_r1_no_short_match: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q.fill < FILL_W'(MFA_BITS - 1)) |-> !match);

    // R10: with no shift and no clear the window is frozen
    a_r10_window_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !clear) |=> $stable(win_q));
endmodule

// File: rtl/crc4_mf_locker.sv
module crc4_mf_locker
    import crc4_mf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic             match,
    output logic             locked,
    output logic             lock_evt,
    output logic [POS_W-1:0] pos
);
    typedef struct packed {
        lock_state_e      state;
        logic [POS_W-1:0] pos;
    } lk_regs_t;

    lk_regs_t lk_d, lk_q;
    logic [POS_W-1:0] pos_inc;

    always_comb begin
        lk_d     = lk_q;
        lock_evt = 1'b0;
        pos_inc  = POS_W'(lk_q.pos + 1'b1);
        if (clear) begin
            lk_d.state = LK_HUNT;
            lk_d.pos   = '0;
        end else if (tick) begin
            unique case (lk_q.state)
                LK_HUNT: begin
                    if (match) begin
                        lk_d.state = LK_CONFIRM;
                        lk_d.pos   = MFA_END_POS;
                    end
                end
                LK_CONFIRM: begin
                    lk_d.pos = pos_inc;
                    if (pos_inc == MFA_END_POS) begin
                        if (match) begin
                            lk_d.state = LK_LOCKED;
                            lock_evt   = 1'b1;
                        end else begin
                            lk_d.state = LK_HUNT;
                            lk_d.pos   = '0;
                        end
                    end
                end
                LK_LOCKED: lk_d.pos = pos_inc;
                default: begin
                    lk_d.state = LK_HUNT;
                    lk_d.pos   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_q.state <= LK_HUNT;
            lk_q.pos   <= '0;
        end else begin
            lk_q <= lk_d;
        end
    end

    assign locked = (lk_q.state == LK_LOCKED);
    assign pos    = lk_q.pos;

    // R2: lock is entered only from the confirming state
    a_r2_lock_after_confirm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(lk_q.state == LK_CONFIRM));

    // R4: position advances by one per frame while locked
    a_r4_pos_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && tick && !clear) |=> (lk_q.pos == POS_W'($past(lk_q.pos) + 1'b1)));

    // R10: no frame strobe, no change
    a_r10_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> ($stable(lk_q.state) && $stable(lk_q.pos)));
endmodule

// File: rtl/crc4_iw_timer.sv
module crc4_iw_timer #(
    parameter int TIMEOUT_FRAMES = 3200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    input  logic lock_evt,
    input  logic iw_off,
    output logic iw_mode
);
    localparam int CNT_W = $clog2(TIMEOUT_FRAMES + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TIMEOUT_FRAMES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             decided;
        logic             iw;
    } tm_regs_t;

    tm_regs_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (clear) begin
            tm_d = '0;
        end else if (tick && !tm_q.decided) begin
            if (lock_evt) begin
                tm_d.decided = 1'b1;
            end else if (tm_q.cnt == LAST_CNT) begin
                tm_d.decided = 1'b1;
                tm_d.iw      = !iw_off;
            end else begin
                tm_d.cnt = CNT_W'(tm_q.cnt + 1'b1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign iw_mode = tm_q.iw;

    // R8: once non-CRC-4 working is chosen it stays until alignment loss
    a_r8_iw_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (tm_q.iw && !clear) |=> tm_q.iw);

    // R7: a CRC-4 decision is never overturned
    a_r7_crc_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (tm_q.decided && !tm_q.iw && !clear) |=> !tm_q.iw);

    // R9: the mode only rises when interworking was enabled
    a_r9_off_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tm_q.iw) |-> $past(!iw_off));

    // R6: no early expiry before the final timer frame
    a_r6_no_early: assert property (@(posedge clk) disable iff (!rst_n)
        (!tm_q.decided && (tm_q.cnt != LAST_CNT)) |=> !tm_q.iw);
endmodule

// File: rtl/crc4_mf_align.sv
module crc4_mf_align
    import crc4_mf_pkg::*;
#(
    parameter int TIMEOUT_FRAMES = 3200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bas_sync,
    input  logic             frm_valid,
    input  logic             frm_nfas,
    input  logic             frm_bit1,
    input  logic             interwork_off,
    output logic             crc_sync_n,
    output logic             iw_status,
    output logic             rx_crc_en,
    output logic             tx_ebit_zero,
    output logic [POS_W-1:0] mf_pos
);
    logic clear, tick, shift_en, match;
    logic locked, lock_evt, iw_mode;
    logic [POS_W-1:0] pos;

    assign clear    = !bas_sync;
    assign tick     = frm_valid && bas_sync;
    assign shift_en = tick && frm_nfas;

    crc4_mfa_window u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .shift_en (shift_en),
        .bit_in   (frm_bit1),
        .match    (match)
    );

    crc4_mf_locker u_locker (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .tick     (tick),
        .match    (match),
        .locked   (locked),
        .lock_evt (lock_evt),
        .pos      (pos)
    );

    crc4_iw_timer #(
        .TIMEOUT_FRAMES (TIMEOUT_FRAMES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .tick     (tick),
        .lock_evt (lock_evt),
        .iw_off   (interwork_off),
        .iw_mode  (iw_mode)
    );

    assign crc_sync_n   = !locked;
    assign iw_status    = iw_mode;
    assign tx_ebit_zero = iw_mode;
    assign rx_crc_en    = locked && !iw_mode;
    assign mf_pos       = locked ? pos : '0;

    // R5: losing basic alignment returns every output to its idle value
    a_r5_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !bas_sync |=> (crc_sync_n && !iw_status && !rx_crc_en && !tx_ebit_zero && (mf_pos == '0)));
endmodule

// File: tb/tb_crc4_mf_align.sv
`timescale 1ns/1ps
module tb_crc4_mf_align;
    localparam int TO = 40;
    localparam int NEVER = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bas_sync = 1'b0, frm_valid = 1'b0, frm_nfas = 1'b0, frm_bit1 = 1'b0;
    logic interwork_off = 1'b0;
    logic crc_sync_n, iw_status, rx_crc_en, tx_ebit_zero;
    logic [3:0] mf_pos;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    crc4_mf_align #(.TIMEOUT_FRAMES(TO)) dut (
        .clk(clk), .rst_n(rst_n), .bas_sync(bas_sync), .frm_valid(frm_valid),
        .frm_nfas(frm_nfas), .frm_bit1(frm_bit1), .interwork_off(interwork_off),
        .crc_sync_n(crc_sync_n), .iw_status(iw_status), .rx_crc_en(rx_crc_en),
        .tx_ebit_zero(tx_ebit_zero), .mf_pos(mf_pos)
    );

    task automatic check_eq(string tg, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tg, what, act, exp);
        end
    endtask

    // bit 1 of an odd frame at multiframe position p carrying the 001011 word
    function automatic logic word_bit(int p);
        logic [5:0] w = 6'b001011;
        return w[5 - (p - 1) / 2];
    endfunction

    function automatic int first_end(int p0);
        return (p0 <= 1) ? (11 - p0) : (27 - p0);
    endfunction

    task automatic idle_outputs(string tg);
        check_eq(tg, "crc_sync_n", int'(crc_sync_n), 1);
        check_eq(tg, "iw_status", int'(iw_status), 0);
        check_eq(tg, "tx_ebit_zero", int'(tx_ebit_zero), 0);
        check_eq(tg, "rx_crc_en", int'(rx_crc_en), 0);
        check_eq(tg, "mf_pos", int'(mf_pos), 0);
    endtask

    // one frame strobe, then sample at the falling edge after the registering edge
    task automatic send_frame(int p, logic bit1);
        @(negedge clk);
        frm_valid = 1'b1;
        frm_nfas  = logic'(p % 2);
        frm_bit1  = bit1;
        @(negedge clk);
        frm_valid = 1'b0;
        frm_bit1  = logic'($urandom_range(0, 1));
        frm_nfas  = logic'($urandom_range(0, 1));
    endtask

    task automatic gap();
        int n = $urandom_range(0, 3);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // mode: 0 = clean far end, 1 = one error in the confirming word, 2 = no CRC-4 word at all
    task automatic run_case(string tg, int p0, int mode, bit off, int nfr);
        int lock_t, err_t, p;
        bit lk, iw_e;
        logic b;
        lock_t = (mode == 2) ? NEVER : first_end(p0) + 16 + ((mode == 1) ? 32 : 0);
        err_t  = (mode == 1) ? first_end(p0) + 6 : -1;
        interwork_off = off;
        @(negedge clk);
        bas_sync = 1'b1;
        for (int t = 0; t < nfr; t++) begin
            p = (p0 + t) % 16;
            if (p % 2 == 0)            b = logic'($urandom_range(0, 1)); // R11: even-frame bits random
            else if (p >= 13)          b = logic'($urandom_range(0, 1));
            else if (mode == 2)        b = 1'b1;
            else                       b = word_bit(p);
            if (t == err_t) b = ~b;
            send_frame(p, b);
            lk   = (t >= lock_t);
            iw_e = !off && (lock_t > TO - 1) && (t >= TO - 1);
            check_eq(tg, "crc_sync_n (R1 R2 R3)", int'(crc_sync_n), int'(!lk));
            check_eq(tg, "iw_status (R6 R7 R8 R9)", int'(iw_status), int'(iw_e));
            check_eq(tg, "tx_ebit_zero (R6)", int'(tx_ebit_zero), int'(iw_e));
            check_eq(tg, "rx_crc_en (R7 R8)", int'(rx_crc_en), int'(lk && !iw_e));
            check_eq(tg, "mf_pos (R4)", int'(mf_pos), lk ? p : 0);
            gap(); // R10: idle cycles between strobes
        end
        @(negedge clk);
        bas_sync = 1'b0;
        @(negedge clk);
        idle_outputs("R5 after alignment loss");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        idle_outputs("R5 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        idle_outputs("R5 after reset");

        // R10: strobes with bas_sync low leave everything idle
        for (int t = 0; t < 40; t++) begin
            send_frame(t % 16, ((t % 2) == 1 && (t % 16) <= 11) ? word_bit(t % 16) : 1'b0);
            idle_outputs("R10 no basic alignment");
        end

        run_case("R2", 0, 0, 1'b0, 60);
        run_case("R7", 1, 0, 1'b0, 60);
        run_case("R7 lock on expiry frame", 4, 0, 1'b0, 60);
        run_case("R8 lock one frame late", 3, 0, 1'b0, 60);
        run_case("R8", 2, 0, 1'b0, 70);
        run_case("R6", 5, 2, 1'b0, 60);
        run_case("R3", 0, 1, 1'b0, 80);
        run_case("R9", 2, 1, 1'b1, 80);
        run_case("R9 no word", 7, 2, 1'b1, 60);
        for (int k = 0; k < 8; k++) begin
            run_case("R1 random", $urandom_range(0, 15), $urandom_range(0, 1),
                     bit'($urandom_range(0, 1)), 80);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule